// File: doc/BRIEF.md
# Sector-Clamped Space Vector Gate Generator

This block drives the six gate signals of a two-level, three-phase voltage source inverter with a space vector scheme that never applies a zero vector. In every switching period only the two active vectors bordering the reference are used. One leg is therefore tied to the positive rail for the whole period and one leg to the negative rail, and only the third leg switches. A leg stays quiet across two neighbouring sectors, so each period carries one third of the switching events of a scheme that also applies zero vectors.

An upstream controller supplies a sector number and two dwell-time words. At each period boundary the block samples them, rescales the first dwell time into a share of a fixed, programmable period, and applies that share to the switching leg. A programmable blanking gap is inserted whenever a leg moves between its upper and lower switch. An invalid sector, or dwell words that sum to zero, turns every gate off and raises a fault flag for that period.

Top module: `clamped_svm_gen`

## Requirements
- R1: While reset is held, and after reset until the first period boundary has taken effect, all six gates are off and `fault` is 0.
- R2: A free-running counter wraps every `periodLen` cycles. `sectorIn`, `dwell1` and `dwell2` are sampled only at the wrap, so a change in mid-period has no effect until the next boundary. `fault` changes only just after a boundary.
- R3: The sector is encoded as the binary values 1 to 6, and gate bit 0 is leg A, bit 1 is leg B and bit 2 is leg C. Each sector sets one leg clamped high (upper gate on), one clamped low (lower gate on) and one switching leg, as (high, low, switching): 1 = (A, C, B), 2 = (B, C, A), 3 = (B, A, C), 4 = (C, A, B), 5 = (C, B, A), 6 = (A, B, C).
- R4: Let share = floor(dwell1 × periodLen / (dwell1 + dwell2)). In even sectors the switching leg commands its upper switch for the first share cycles of each period. In odd sectors it does so for the first periodLen − share cycles. For the rest of the period it commands the lower switch.
- R5: Each time a leg moves between its upper and lower switch, both of its gates stay off for `deadTime` + 1 cycles before the new gate turns on.
- R6: The upper and lower gate of a leg are never on in the same cycle, including across sector changes.
- R7: A sample with `sectorIn` equal to 0 or 7, or with `dwell1` + `dwell2` equal to 0, sets `fault` and turns all gates off for that period. The next valid sample clears `fault`.
- R8: When either dwell word is 0, the switching leg does not switch during the period: it holds one gate on for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| periodLen | input | CNT_W | Switching period in cycles (at least 2) |
| deadTime | input | DT_W | Blanking gap length minus one |
| sectorIn | input | 3 | Reference sector, valid values 1 to 6 |
| dwell1 | input | T_W | Dwell time of the first adjacent vector |
| dwell2 | input | T_W | Dwell time of the second adjacent vector |
| gateHi | output | 3 | Upper gates, bit 0 = A, bit 1 = B, bit 2 = C |
| gateLo | output | 3 | Lower gates, same bit order |
| fault | output | 1 | Invalid sample in the current period |

## Verification
The checker watches every cycle for shoot-through on each leg. It checks that every upper-to-lower or lower-to-upper handover is preceded by a long enough off run, that a set fault flag is followed by all gates off, that the flag moves only at a period boundary, and that the counter stays inside the period. The clamp assignment of each sector, the rescaled duty of the switching leg and the effect of mid-period input changes depend on sampled input values and period alignment. Only the bench's sweeps show these, by counting on-cycles of every gate over whole periods and by watching the exact boundary at which a sector change appears.

// File: rtl/svm_pkg.sv
package svm_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_UP  = 2'd1,
    LEG_DN  = 2'd2
  } legCmd_t;

  typedef struct packed {
    logic load;
    logic accept;
    logic reject;
  } svmStrobe_t;

  typedef struct packed {
    logic [1:0] hiLeg;
    logic [1:0] loLeg;
    logic [1:0] pwmLeg;
  } legRoles_t;

  // leg index: 0 = A, 1 = B, 2 = C
  function automatic legRoles_t rolesOf(input logic [2:0] sec);
    legRoles_t r;
    case (sec)
      3'd1:    r = {2'd0, 2'd2, 2'd1};
      3'd2:    r = {2'd1, 2'd2, 2'd0};
      3'd3:    r = {2'd1, 2'd0, 2'd2};
      3'd4:    r = {2'd2, 2'd0, 2'd1};
      3'd5:    r = {2'd2, 2'd1, 2'd0};
      default: r = {2'd0, 2'd1, 2'd2};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/svm_ctrl.sv
module svm_ctrl
  import svm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodLen,
  input  logic [2:0]       sectorIn,
  input  logic [T_W-1:0]   dwell1,
  input  logic [T_W-1:0]   dwell2,
  output logic [CNT_W-1:0] cnt,
  output svmStrobe_t       strobe,
  output logic             fault
);
  localparam int SUM_W = T_W + 1;

  logic wrap;
  logic validIn;
  logic [SUM_W-1:0] dwellSum;

  assign wrap     = (cnt >= periodLen - CNT_W'(1));
  assign dwellSum = SUM_W'(dwell1) + SUM_W'(dwell2);
  assign validIn  = (sectorIn != 3'd0) && (sectorIn != 3'd7) && (dwellSum != '0);

  assign strobe.load   = wrap;
  assign strobe.accept = wrap && validIn;
  assign strobe.reject = wrap && !validIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
      if (strobe.reject)      fault <= 1'b1;
      else if (strobe.accept) fault <= 1'b0;
    end
  end

endmodule

// File: rtl/svm_deadband.sv
module svm_deadband
  import svm_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  legCmd_t         cmd,
  input  logic [DT_W-1:0] deadTime,
  output logic            hiOn,
  output logic            loOn
);
  legCmd_t         applied;
  logic [DT_W-1:0] gapLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      applied <= LEG_OFF;
      gapLeft <= '0;
    end else if (applied != LEG_OFF && cmd != applied) begin
      applied <= LEG_OFF;
      gapLeft <= deadTime;
    end else if (applied == LEG_OFF) begin
      if (gapLeft != '0) gapLeft <= gapLeft - DT_W'(1);
      else               applied <= cmd;
    end
  end

  assign hiOn = (applied == LEG_UP);
  assign loOn = (applied == LEG_DN);

endmodule

// File: rtl/svm_datapath.sv
module svm_datapath
  import svm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_W   = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  svmStrobe_t       strobe,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] periodLen,
  input  logic [DT_W-1:0]  deadTime,
  input  logic [2:0]       sectorIn,
  input  logic [T_W-1:0]   dwell1,
  input  logic [T_W-1:0]   dwell2,
  output logic [2:0]       gateHi,
  output logic [2:0]       gateLo
);
  localparam int PROD_W = T_W + CNT_W;
  localparam int LEGS   = 3;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] divisor;
  logic [CNT_W-1:0]  firstShare;
  logic [CNT_W-1:0]  onNext;

  logic              active;
  logic [2:0]        secReg;
  logic [CNT_W-1:0]  onReg;

  legRoles_t roles;
  legCmd_t   pwmCmd;
  legCmd_t   legCmd [LEGS];

  always_comb begin
    prod       = PROD_W'(dwell1) * PROD_W'(periodLen);
    divisor    = PROD_W'(dwell1) + PROD_W'(dwell2);
    if (divisor == '0) divisor = PROD_W'(1);
    firstShare = CNT_W'(prod / divisor);
    onNext     = sectorIn[0] ? periodLen - firstShare : firstShare;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      secReg <= 3'd1;
      onReg  <= '0;
    end else if (strobe.accept) begin
      active <= 1'b1;
      secReg <= sectorIn;
      onReg  <= onNext;
    end else if (strobe.reject) begin
      active <= 1'b0;
    end
  end

  assign roles  = rolesOf(secReg);
  assign pwmCmd = (cnt < onReg) ? LEG_UP : LEG_DN;

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    always_comb begin
      if (!active)                    legCmd[i] = LEG_OFF;
      else if (roles.hiLeg == 2'(i))  legCmd[i] = LEG_UP;
      else if (roles.loLeg == 2'(i))  legCmd[i] = LEG_DN;
      else                            legCmd[i] = pwmCmd;
    end

    svm_deadband #(.DT_W(DT_W)) u_band (
      .clk     (clk),
      .rstN    (rstN),
      .cmd     (legCmd[i]),
      .deadTime(deadTime),
      .hiOn    (gateHi[i]),
      .loOn    (gateLo[i])
    );
  end

endmodule

// File: rtl/clamped_svm_gen.sv
module clamped_svm_gen
  import svm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_W   = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodLen,
  input  logic [DT_W-1:0]  deadTime,
  input  logic [2:0]       sectorIn,
  input  logic [T_W-1:0]   dwell1,
  input  logic [T_W-1:0]   dwell2,
  output logic [2:0]       gateHi,
  output logic [2:0]       gateLo,
  output logic             fault
);
  svmStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;

  svm_ctrl #(.CNT_W(CNT_W), .T_W(T_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .periodLen(periodLen),
    .sectorIn (sectorIn),
    .dwell1   (dwell1),
    .dwell2   (dwell2),
    .cnt      (cnt),
    .strobe   (strobe),
    .fault    (fault)
  );

  svm_datapath #(.CNT_W(CNT_W), .T_W(T_W), .DT_W(DT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cnt      (cnt),
    .periodLen(periodLen),
    .deadTime (deadTime),
    .sectorIn (sectorIn),
    .dwell1   (dwell1),
    .dwell2   (dwell2),
    .gateHi   (gateHi),
    .gateLo   (gateLo)
  );

endmodule

// File: rtl/clamped_svm_gen_chk.sv
module clamped_svm_gen_chk #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       gateHi,
  input logic [2:0]       gateLo,
  input logic             fault,
  input logic [DT_W-1:0]  deadTime,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] periodLen
);
  for (genvar i = 0; i < 3; i++) begin : g_leg
    logic [DT_W:0] offRun;
    logic          wasHi;
    logic          wasLo;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        offRun <= '0;
        wasHi  <= 1'b0;
        wasLo  <= 1'b0;
      end else begin
        if (!gateHi[i] && !gateLo[i]) begin
          if (offRun != '1) offRun <= offRun + 1'b1;
        end else begin
          offRun <= '0;
        end
        if (gateHi[i]) begin wasHi <= 1'b1; wasLo <= 1'b0; end
        if (gateLo[i]) begin wasLo <= 1'b1; wasHi <= 1'b0; end
      end
    end

    // R6
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[i] && gateLo[i]));

    // R5
    gap_to_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateLo[i]) && wasHi) |-> (offRun > {1'b0, deadTime}));

    // R5
    gap_to_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateHi[i]) && wasLo) |-> (offRun > {1'b0, deadTime}));
  end

  // R7
  fault_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> (gateHi == 3'b000 && gateLo == 3'b000));

  // R2
  fault_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fault) |-> $past(load));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < periodLen);

endmodule

bind clamped_svm_gen clamped_svm_gen_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .gateHi   (gateHi),
  .gateLo   (gateLo),
  .fault    (fault),
  .deadTime (deadTime),
  .load     (strobe.load),
  .cnt      (cnt),
  .periodLen(periodLen)
);

// File: tb/clamped_svm_gen_tb.sv
module clamped_svm_gen_tb;
  localparam int TS = 20;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] periodLen;
  logic [3:0] deadTime;
  logic [2:0] sectorIn;
  logic [7:0] dwell1, dwell2;
  logic [2:0] gateHi, gateLo;
  logic       fault;

  int checks = 0;
  int errors = 0;
  int edges;
  int hiC [3];
  int loC [3];
  int bothOn;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edges <= 0;
    else       edges <= edges + 1;
  end

  clamped_svm_gen u_dut (
    .clk(clk), .rstN(rstN), .periodLen(periodLen), .deadTime(deadTime),
    .sectorIn(sectorIn), .dwell1(dwell1), .dwell2(dwell2),
    .gateHi(gateHi), .gateLo(gateLo), .fault(fault)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure();
    bothOn = 0;
    for (int l = 0; l < 3; l++) begin hiC[l] = 0; loC[l] = 0; end
    repeat (TS) begin
      @(negedge clk);
      for (int l = 0; l < 3; l++) begin
        hiC[l] += int'(gateHi[l]);
        loC[l] += int'(gateLo[l]);
        if (gateHi[l] && gateLo[l]) bothOn++;
      end
    end
  endtask

  // clamp table of R3: high, low, switching leg
  task automatic rolesOf(input int s, output int hi, output int lo, output int pw);
    case (s)
      1: begin hi = 0; lo = 2; pw = 1; end
      2: begin hi = 1; lo = 2; pw = 0; end
      3: begin hi = 1; lo = 0; pw = 2; end
      4: begin hi = 2; lo = 0; pw = 1; end
      5: begin hi = 2; lo = 1; pw = 0; end
      default: begin hi = 0; lo = 1; pw = 2; end
    endcase
  endtask

  task automatic sweep(input int dt);
    int t1s [6] = '{1, 3, 1, 0, 5, 7};
    int t2s [6] = '{1, 1, 3, 5, 0, 2};
    for (int s = 1; s <= 6; s++) begin
      for (int p = 0; p < 6; p++) begin
        int hi, lo, pw, share, onC, eh, el;
        @(negedge clk);
        sectorIn = 3'(s); dwell1 = 8'(t1s[p]); dwell2 = 8'(t2s[p]);
        repeat (3 * TS) @(negedge clk);
        measure();
        rolesOf(s, hi, lo, pw);
        share = (t1s[p] * TS) / (t1s[p] + t2s[p]);
        onC = (s % 2 == 0) ? share : TS - share;
        check("R3", $sformatf("s%0d clamp-high upper", s), hiC[hi], TS);
        check("R3", $sformatf("s%0d clamp-low lower", s), loC[lo], TS);
        if (onC == 0 || onC == TS) begin
          // R8: constant switching leg
          eh = (onC == TS) ? TS : 0;
          el = TS - eh;
          check("R8", $sformatf("s%0d t1=%0d t2=%0d pwm upper", s, t1s[p], t2s[p]), hiC[pw], eh);
          check("R8", $sformatf("s%0d t1=%0d t2=%0d pwm lower", s, t1s[p], t2s[p]), loC[pw], el);
        end else begin
          // R4 duty and R5 gap cost
          check("R4", $sformatf("s%0d t1=%0d t2=%0d dt=%0d pwm upper", s, t1s[p], t2s[p], dt), hiC[pw], onC - dt - 1);
          check("R5", $sformatf("s%0d t1=%0d t2=%0d dt=%0d pwm lower", s, t1s[p], t2s[p], dt), loC[pw], TS - onC - dt - 1);
        end
        check("R6", $sformatf("s%0d both-on samples", s), bothOn, 0);
      end
    end
  endtask

  task automatic faultCase(input int s, input int t1, input int t2, input string what);
    @(negedge clk);
    sectorIn = 3'(s); dwell1 = 8'(t1); dwell2 = 8'(t2);
    repeat (2 * TS + 2) @(negedge clk);
    check("R7", {what, " fault"}, int'(fault), 1);
    measure();
    check("R7", {what, " gates on"}, hiC[0] + hiC[1] + hiC[2] + loC[0] + loC[1] + loC[2], 0);
  endtask

  initial begin
    int cnt1, bad;
    rstN = 1'b0; periodLen = 8'(TS); deadTime = 4'd0;
    sectorIn = 3'd1; dwell1 = 8'd1; dwell2 = 8'd1;
    repeat (3) @(negedge clk);
    check("R1", "fault in reset", int'(fault), 0);
    check("R1", "gates in reset", int'({gateHi, gateLo}), 0);
    rstN = 1'b1;
    bad = 0;
    repeat (TS - 1) begin
      @(negedge clk);
      if (gateHi != 3'b000 || gateLo != 3'b000 || fault) bad++;
    end
    check("R1", "active samples before first boundary", bad, 0);

    sweep(0);

    faultCase(7, 2, 3, "sector 7");
    faultCase(0, 2, 3, "sector 0");
    deadTime = 4'd2;
    faultCase(3, 0, 0, "zero dwell sum");
    @(negedge clk);
    sectorIn = 3'd3; dwell1 = 8'd2; dwell2 = 8'd3;
    repeat (2 * TS + 2) @(negedge clk);
    check("R7", "fault cleared by valid sample", int'(fault), 0);

    sweep(2);

    // R2: mid-period change waits for the boundary
    @(negedge clk);
    sectorIn = 3'd7;
    repeat (2 * TS + 2) @(negedge clk);
    deadTime = 4'd1;
    sectorIn = 3'd1; dwell1 = 8'd1; dwell2 = 8'd1;
    repeat (3 * TS) @(negedge clk);
    do @(negedge clk); while (edges % TS != 0);
    sectorIn = 3'd4; dwell1 = 8'd3; dwell2 = 8'd1;
    cnt1 = 0;
    repeat (TS) begin
      @(negedge clk);
      cnt1 += int'(gateHi[0]);
    end
    check("R2", "leg A upper held until boundary", cnt1, TS);
    @(negedge clk);
    check("R2", "leg A upper after boundary", int'(gateHi[0]), 0);
    check("R5", "leg A lower in gap 1", int'(gateLo[0]), 0);
    @(negedge clk);
    check("R5", "leg A lower in gap 2", int'(gateLo[0]), 0);
    @(negedge clk);
    check("R5", "leg A lower after gap", int'(gateLo[0]), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule